// File: doc/BRIEF.md
# Quarter-Wave Sine/Cosine Lookup

This block turns a phase word into a signed sine sample and a signed cosine sample in the same cycle. It is meant to sit between a phase accumulator and the multipliers of a complex mixer. Only the first quadrant of the wave is held in a table of unsigned magnitudes. The top phase bit selects the output sign. The next bit selects whether the table address is used as it is or bit-inverted. The cosine comes from the same table, read through a second port at the phase advanced by a quarter cycle.

The table holds 2^(PHASE_W-2) words. Each word is AMP_W-1 bits wide, so its size follows from the two port widths. Entries are sampled half a phase step off the grid, so the reflected halves join cleanly at the quadrant edges. `PIPE` (0 to 10) sets the number of clock stages from input to output. With 0 the path is purely combinational. With 1 or more, the first stage is the table's read register, so block RAM can be inferred.

Top module: `sc_quarter_lut`

## Requirements
- R1: With N = 2^PHASE_W and A = 2^(AMP_W-1)-1, `out_sin` for phase p lies within 1 LSB of A·sin(2π(p+0.5)/N).
- R2: `out_cos` for phase p lies within 1 LSB of A·cos(2π(p+0.5)/N), and it equals exactly the `out_sin` value produced for phase (p + N/4) mod N.
- R3: Outputs and `out_valid` for an input appear exactly PIPE rising edges after that input is sampled. With PIPE = 0 they follow the inputs combinationally.
- R4: For every phase p, `out_sin` at p + N/2 is the exact two's-complement negation of `out_sin` at p (the phase MSB is the sign).
- R5: Within a half cycle, `out_sin` at p equals `out_sin` at N/2-1-p exactly: when bit PHASE_W-2 is set, the quadrant address is bit-inverted.
- R6: For every phase, sqrt(out_sin² + out_cos²) lies within 1 LSB of A.
- R7: No output magnitude exceeds A, so the most negative code -2^(AMP_W-1) never appears.
- R8: A synchronous active-high `rst` clears the valid pipeline. `out_valid` is low after any edge that samples `rst` high, and it stays low until a valid input sampled after reset has travelled through all PIPE stages.
- R9: `out_valid` reproduces the `in_valid` pattern, bubbles included, delayed by PIPE cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Phase word is valid |
| in_phase | input | PHASE_W | Phase, one full cycle spans 2^PHASE_W codes |
| out_valid | output | 1 | Outputs valid, aligned with the samples |
| out_sin | output | AMP_W | Signed sine sample |
| out_cos | output | AMP_W | Signed cosine sample |

## Verification
The sine read and the cosine read hit the shared quarter table in the same cycle. For every phase they land in neighbouring quadrants, so one port reads a reflected address while the other reads a direct one, and their signs can differ. A scrambled sweep drives every phase code with valid bubbles mixed in, through a pipelined instance and a combinational instance. Each result is judged against real-valued sine and cosine within 1 LSB. The cosine table is then compared bit-exactly with the sine table shifted by a quarter cycle, and the half-cycle and mirror symmetries are checked exactly.

// File: rtl/sc_quarter_pkg.sv
package sc_quarter_pkg;

  localparam int PIPE_MAX = 10;

  // Magnitude of one quadrant sample, taken half a step off the grid.
  function automatic int quarter_mag(int idx, int depth, int amax);
    real ang;
    real x;
    ang = (3.14159265358979 / 2.0) * (real'(idx) + 0.5) / real'(depth);
    x   = real'(amax) * $sin(ang);
    return $rtoi(x + 0.5);
  endfunction

endpackage

// File: rtl/sc_fold.sv
module sc_fold #(
  parameter int PHASE_W = 10
) (
  input  logic [PHASE_W-1:0] phase,
  output logic [PHASE_W-3:0] addr,
  output logic               neg
);
  // Top bit picks the sign, next bit reflects the address within the quadrant.
  always_comb begin
    neg  = phase[PHASE_W-1];
    addr = phase[PHASE_W-2] ? ~phase[PHASE_W-3:0] : phase[PHASE_W-3:0];
  end
endmodule

// File: rtl/sc_qrom.sv
module sc_qrom #(
  parameter int ADDR_W = 8,
  parameter int MAG_W  = 11,
  parameter bit REG_RD = 1'b1
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  output logic [MAG_W-1:0]  mag_a,
  output logic [MAG_W-1:0]  mag_b
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int AMAX  = (1 << MAG_W) - 1;

  logic [MAG_W-1:0] store [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      store[i] = MAG_W'(sc_quarter_pkg::quarter_mag(i, DEPTH, AMAX));
  end

  generate
    if (REG_RD) begin : g_reg
      // Registered dual read, no reset, so block RAM can be inferred.
      always_ff @(posedge clk) begin
        mag_a <= store[addr_a];
        mag_b <= store[addr_b];
      end
    end else begin : g_comb
      assign mag_a = store[addr_a];
      assign mag_b = store[addr_b];
    end
  endgenerate
endmodule

// File: rtl/sc_delay.sv
module sc_delay #(
  parameter int W = 1,
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (N == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] stg [N];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < N; i++) stg[i] <= '0;
        end else begin
          stg[0] <= d;
          for (int i = 1; i < N; i++) stg[i] <= stg[i-1];
        end
      end
      assign q = stg[N-1];
    end
  endgenerate
endmodule

// File: rtl/sc_quarter_lut.sv
module sc_quarter_lut #(
  parameter int PHASE_W = 10,
  parameter int AMP_W   = 12,
  parameter int PIPE    = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [PHASE_W-1:0]      in_phase,
  output logic                    out_valid,
  output logic signed [AMP_W-1:0] out_sin,
  output logic signed [AMP_W-1:0] out_cos
);
  localparam int ADDR_W = PHASE_W - 2;
  localparam int MAG_W  = AMP_W - 1;
  localparam int RD_LAT = (PIPE > 0) ? 1 : 0;
  localparam int TAIL   = PIPE - RD_LAT;
  localparam logic [PHASE_W-1:0] QUARTER = PHASE_W'(1) << (PHASE_W - 2);
  localparam logic signed [AMP_W-1:0] MIN_CODE = {1'b1, {(AMP_W-1){1'b0}}};

  generate
    if (PIPE < 0 || PIPE > sc_quarter_pkg::PIPE_MAX) begin : g_bad_pipe
      $error("sc_quarter_lut: PIPE out of range");
    end
  endgenerate

  // Fold both phases onto the quadrant table.
  logic [PHASE_W-1:0] cos_phase;
  logic [ADDR_W-1:0]  s_addr, c_addr;
  logic               s_neg, c_neg;

  assign cos_phase = in_phase + QUARTER;

  sc_fold #(.PHASE_W(PHASE_W)) u_fold_s (.phase(in_phase),  .addr(s_addr), .neg(s_neg));
  sc_fold #(.PHASE_W(PHASE_W)) u_fold_c (.phase(cos_phase), .addr(c_addr), .neg(c_neg));

  // One store, two read ports.
  logic [MAG_W-1:0] s_mag, c_mag;

  sc_qrom #(.ADDR_W(ADDR_W), .MAG_W(MAG_W), .REG_RD(PIPE > 0)) u_rom (
    .clk(clk), .addr_a(s_addr), .addr_b(c_addr), .mag_a(s_mag), .mag_b(c_mag)
  );

  // Side band aligned with the table read.
  logic [2:0] side_d;
  sc_delay #(.W(3), .N(RD_LAT)) u_side (
    .clk(clk), .rst(rst), .d({in_valid, s_neg, c_neg}), .q(side_d)
  );

  // Sign restore.
  logic signed [AMP_W-1:0] sin_v, cos_v;
  always_comb begin
    sin_v = side_d[1] ? -$signed({1'b0, s_mag}) : $signed({1'b0, s_mag});
    cos_v = side_d[0] ? -$signed({1'b0, c_mag}) : $signed({1'b0, c_mag});
  end

  // Remaining stages.
  logic [2*AMP_W:0] tail_q;
  sc_delay #(.W(2*AMP_W+1), .N(TAIL)) u_tail (
    .clk(clk), .rst(rst), .d({side_d[2], sin_v, cos_v}), .q(tail_q)
  );

  assign out_valid = tail_q[2*AMP_W];
  assign out_sin   = tail_q[2*AMP_W-1:AMP_W];
  assign out_cos   = tail_q[AMP_W-1:0];

  // Checks.
  logic [3:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 4'(PIPE)) since_rst <= since_rst + 4'd1;
  end

  // R2: the cosine phase always lands in the neighbouring quadrant.
  p_addr_complement_r2: assert property (@(posedge clk) disable iff (rst)
    s_addr == ~c_addr);

  // R7: the most negative code never leaves the block.
  p_no_min_code_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sin != MIN_CODE && out_cos != MIN_CODE));

  generate
    if (PIPE > 0) begin : g_seq_chk
      // R3 / R9: valid emerges exactly PIPE edges later.
      p_latency_r3: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 4'(PIPE)) |-> (out_valid == $past(in_valid, PIPE)));
      // R8: reset empties the pipeline.
      p_reset_clear_r8: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);
    end
  endgenerate
endmodule

// File: tb/sc_quarter_lut_test.sv
`timescale 1ns/1ps
module sc_quarter_lut_test;
  localparam int PW   = 10;
  localparam int AW   = 12;
  localparam int PIPE = 3;
  localparam int N    = 1 << PW;
  localparam int D    = N / 4;
  localparam int AMAX = (1 << (AW - 1)) - 1;
  localparam int HMAX = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [PW-1:0] in_phase = '0;
  logic out_valid, out_valid0;
  logic signed [AW-1:0] out_sin, out_cos, out_sin0, out_cos0;

  always #2.5 clk = ~clk;

  sc_quarter_lut #(.PHASE_W(PW), .AMP_W(AW), .PIPE(PIPE)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_phase(in_phase),
    .out_valid(out_valid), .out_sin(out_sin), .out_cos(out_cos)
  );

  sc_quarter_lut #(.PHASE_W(PW), .AMP_W(AW), .PIPE(0)) uut0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_phase(in_phase),
    .out_valid(out_valid0), .out_sin(out_sin0), .out_cos(out_cos0)
  );

  int checks = 0;
  int errors = 0;
  int sres [N];
  int cres [N];
  int ph_hist [HMAX];
  bit v_hist [HMAX];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int model(input int p, input bit cosine);
    real ang, x;
    ang = 2.0 * 3.14159265358979 * (real'(p) + 0.5) / real'(N);
    x = real'(AMAX) * (cosine ? $cos(ang) : $sin(ang));
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic int absi(input int v);
    return (v < 0) ? -v : v;
  endfunction

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    int k;
    int last_drive;
    int p;
    int e;
    cnt = 0;
    k = 0;
    last_drive = -1;
    repeat (4) @(negedge clk);
    // R8: reset state.
    check(out_valid == 1'b0, "R8 reset", int'(out_valid), 0);
    rst = 1'b0;

    // Scrambled sweep of every phase with valid bubbles.
    while (cnt < N || k <= last_drive + PIPE) begin
      @(negedge clk);
      if (k >= PIPE) begin
        int idx;
        idx = k - PIPE;
        check(out_valid == v_hist[idx], "R9 valid pattern", int'(out_valid), int'(v_hist[idx]));
        if (v_hist[idx] && out_valid) begin
          p = ph_hist[idx];
          e = model(p, 1'b0);
          check(absi(int'(out_sin) - e) <= 1, "R1 sine", int'(out_sin), e);
          e = model(p, 1'b1);
          check(absi(int'(out_cos) - e) <= 1, "R2 cosine", int'(out_cos), e);
          sres[p] = int'(out_sin);
          cres[p] = int'(out_cos);
        end
      end
      if (cnt < N) begin
        in_valid = ((k % 9) != 4);
        if (in_valid) begin
          in_phase = PW'((cnt * 389) % N);
          cnt++;
        end else begin
          in_phase = PW'(k * 5);
        end
        last_drive = k;
      end else begin
        in_valid = 1'b0;
      end
      ph_hist[k] = int'(in_phase);
      v_hist[k] = in_valid;
      #1;
      // R3: zero-stage instance follows combinationally.
      check(out_valid0 == in_valid, "R3 comb valid", int'(out_valid0), int'(in_valid));
      if (in_valid) begin
        e = model(int'(in_phase), 1'b0);
        check(absi(int'(out_sin0) - e) <= 1, "R3 comb sine", int'(out_sin0), e);
        e = model(int'(in_phase), 1'b1);
        check(absi(int'(out_cos0) - e) <= 1, "R3 comb cosine", int'(out_cos0), e);
      end
      k++;
    end

    // Exact symmetry and magnitude checks over the collected tables.
    for (int q = 0; q < N; q++) begin
      int m;
      real r;
      check(sres[q] == -sres[(q + N/2) % N], "R4 half-cycle negation", sres[(q + N/2) % N], -sres[q]);
      if (q < N/2)
        check(sres[q] == sres[N/2 - 1 - q], "R5 mirror", sres[N/2 - 1 - q], sres[q]);
      check(cres[q] == sres[(q + D) % N], "R2 quarter shift", cres[q], sres[(q + D) % N]);
      r = $sqrt(real'(sres[q]) * real'(sres[q]) + real'(cres[q]) * real'(cres[q]));
      m = $rtoi(r + 0.5);
      check((r - real'(AMAX) <= 1.0) && (real'(AMAX) - r <= 1.0), "R6 magnitude", m, AMAX);
      check(absi(sres[q]) <= AMAX && absi(cres[q]) <= AMAX, "R7 bound",
            (absi(sres[q]) > absi(cres[q])) ? absi(sres[q]) : absi(cres[q]), AMAX);
    end

    // Mid-stream reset with valid held high.
    @(negedge clk);
    in_valid = 1'b1;
    in_phase = PW'(D / 2);
    repeat (PIPE + 2) @(negedge clk);
    check(out_valid == 1'b1, "R9 steady valid", int'(out_valid), 1);
    rst = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 reset clears", int'(out_valid), 0);
    rst = 1'b0;
    for (int j = 1; j <= PIPE; j++) begin
      @(negedge clk);
      if (j < PIPE)
        check(out_valid == 1'b0, "R3 refill latency", int'(out_valid), 0);
      else
        check(out_valid == 1'b1, "R3 refill latency", int'(out_valid), 1);
    end
    e = model(D / 2, 1'b0);
    check(absi(int'(out_sin) - e) <= 1, "R1 after reset", int'(out_sin), e);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule